// File: doc/BRIEF.md
# Host Cycle Router for a Content-Addressable Memory

This block sits between a 16-bit host bus and the registers and array of a content-addressable memory. Each clock cycle in which the active-low enable is low counts as one host cycle. The block classifies that cycle from the command/data select and the read/write line. It then names the single internal resource that cycle reaches, raises a write or read strobe for it, and drives the read data with its output enable. The register file, the match logic, the array and the segment counters sit outside the block. They see only the target code and the strobes. Status and register read data come back in on dedicated inputs.

Routing depends on earlier cycles. A command write normally loads the instruction decoder. A command read normally returns the low half of status, and a second read directly after it returns the high half. Several things change this. An instruction with the address-field flag sends the next command write to the address register. A temporary-override instruction redirects exactly one later command cycle. Data cycles go to a persistent source or destination, which stays selected until another select instruction changes it.

Top module: `cam_cycle_router`

## Requirements
- R1: While `bus_en_n` is high, `tgt_o` is 0, both strobes and `dout_oe_o` are low, and no routing state changes. A lower-status read, a deselected cycle, then a command read still returns the upper status half.
- R2: With enable low, `{bus_dsel_i, bus_rd_i}` selects the cycle kind: 00 command write, 01 command read, 10 data write, 11 data read. With nothing pending, a command write targets the instruction decoder (`tgt_o`=1) and pulses `wr_stb_o`. Every read cycle raises `rd_stb_o` and `dout_oe_o`.
- R3: A command write routed to the instruction decoder with bit 11 of the word set sends the next enabled cycle, if it is a command write, to the address register (`tgt_o`=2). Any other enabled cycle in between drops the flag.
- R4: With nothing pending, a command read returns status bits 15:0 (`tgt_o`=6, `dout_o`=`stat_i[15:0]`). A command read immediately after it returns bits 31:16 (`tgt_o`=7). The read after that returns bits 15:0 again.
- R5: Any enabled cycle that is not a command read, following a lower-status read, cancels the pairing. The next command read returns bits 15:0.
- R6: Instruction opcodes 0x11 to 0x16 (bits 7:0) arm an override for the next command cycle. The targets are, in order: address 2, control 3, segment control 4, next-free address 5, persistent-source readback 14, persistent-destination readback 15. The override survives data cycles and applies to one command cycle only. A command read returns `reg_rdata_i` for targets 2 to 5.
- R7: A command write under an override naming 5, 14 or 15 is discarded: `tgt_o`=0, no `wr_stb_o`. The override is still used up.
- R8: After reset, the persistent source and destination are both the comparand (8). Source select opcodes 0x20 to 0x24 choose 8, 9, 10, 11, 13. Destination select opcodes 0x30 to 0x35 choose 8, 9, 10, 11, 12, 13. Other low nibbles in these groups leave the choice unchanged.
- R9: A data read targets the persistent source and returns `reg_rdata_i`. A data write targets the persistent destination with `wr_stb_o`.
- R10: A command read under override 14 returns `{DEV_ID, last source-select opcode}`. Under override 15 it returns `{8'h00, last destination-select opcode}`. After reset these opcodes are 0x20 and 0x30.
- R11: A pending override wins over both the address-field flag and the status pairing. A read taken by the override leaves the next command read at the lower status half.
- R12: Synchronous active-high `rst` clears a pending override, the address-field flag and the status pairing, and restores the comparand as source and destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en_n | input | 1 | Active-low bus enable |
| bus_dsel_i | input | 1 | 0 command cycle, 1 data cycle |
| bus_rd_i | input | 1 | 0 write, 1 read |
| bus_din_i | input | DATA_W | Host write data / instruction word |
| stat_i | input | 2*DATA_W | Status word from the device |
| reg_rdata_i | input | DATA_W | Read data of the targeted register or array port |
| tgt_o | output | 4 | Target code of the current cycle |
| wr_stb_o | output | 1 | Write strobe for the target |
| rd_stb_o | output | 1 | Read strobe for the target |
| dout_oe_o | output | 1 | Host data output enable |
| dout_o | output | DATA_W | Host read data |

## Verification
The main routing is tried with several kinds of cycle sequence. Back-to-back command reads separate the paired status halves from a broken pairing. Instructions with and without bit 11 followed by different cycle kinds show whether the address flag is one-shot or sticky. Overrides placed before data cycles, before reads and before writes show one-shot use, write protection and the priority over the flag and the pairing. Random mixes of select opcodes (valid and invalid) with data cycles and deselected gaps confirm that the persistent choices stay put, and that readback reports the last select opcode.

// File: rtl/cam_rt_pkg.sv
package cam_rt_pkg;
    localparam int OP_W = 8;

    typedef enum logic [3:0] {
        T_NONE   = 4'd0,
        T_INSTR  = 4'd1,
        T_ADDR   = 4'd2,
        T_CTRL   = 4'd3,
        T_SEGCTL = 4'd4,
        T_NFA    = 4'd5,
        T_STLO   = 4'd6,
        T_STHI   = 4'd7,
        T_CMP    = 4'd8,
        T_MSK1   = 4'd9,
        T_MSK2   = 4'd10,
        T_ARR_AR = 4'd11,
        T_ARR_NF = 4'd12,
        T_ARR_HP = 4'd13,
        T_PS_RB  = 4'd14,
        T_PD_RB  = 4'd15
    } tgt_e;

    typedef enum logic [1:0] {
        CY_CMD_WR = 2'b00,
        CY_CMD_RD = 2'b01,
        CY_DAT_WR = 2'b10,
        CY_DAT_RD = 2'b11
    } cyc_e;

    localparam logic [3:0] GRP_OVR  = 4'h1;
    localparam logic [3:0] GRP_PSRC = 4'h2;
    localparam logic [3:0] GRP_PDST = 4'h3;
    localparam logic [OP_W-1:0] OP_PS_CMP = 8'h20;
    localparam logic [OP_W-1:0] OP_PD_CMP = 8'h30;

    typedef struct packed {
        logic            ovr_pend;
        tgt_e            ovr_tgt;
        logic            afl;
        logic            lo_seen;
        tgt_e            ps;
        tgt_e            pd;
        logic [OP_W-1:0] ps_op;
        logic [OP_W-1:0] pd_op;
    } rt_state_t;
endpackage

// File: rtl/cam_cyc_decode.sv
module cam_cyc_decode
    import cam_rt_pkg::*;
(
    input  logic en_n,
    input  logic dsel,
    input  logic rd,
    output logic active,
    output cyc_e kind
);
    always_comb begin
        active = ~en_n;
        kind   = cyc_e'({dsel, rd});
    end
endmodule

// File: rtl/cam_instr_decode.sv
module cam_instr_decode
    import cam_rt_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  logic            af_bit,
    output logic            is_ovr,
    output tgt_e            ovr_tgt,
    output logic            af,
    output logic            ps_ok,
    output tgt_e            ps_tgt,
    output logic            pd_ok,
    output tgt_e            pd_tgt
);
    logic [3:0] grp;
    logic [3:0] sub;

    always_comb begin
        grp     = op[7:4];
        sub     = op[3:0];
        af      = af_bit;
        is_ovr  = 1'b0;
        ovr_tgt = T_NONE;
        ps_ok   = 1'b0;
        ps_tgt  = T_CMP;
        pd_ok   = 1'b0;
        pd_tgt  = T_CMP;
        if (grp == GRP_OVR) begin
            is_ovr = 1'b1;
            case (sub)
                4'd1:    ovr_tgt = T_ADDR;
                4'd2:    ovr_tgt = T_CTRL;
                4'd3:    ovr_tgt = T_SEGCTL;
                4'd4:    ovr_tgt = T_NFA;
                4'd5:    ovr_tgt = T_PS_RB;
                4'd6:    ovr_tgt = T_PD_RB;
                default: is_ovr  = 1'b0;
            endcase
        end
        if (grp == GRP_PSRC) begin
            ps_ok = 1'b1;
            case (sub)
                4'd0:    ps_tgt = T_CMP;
                4'd1:    ps_tgt = T_MSK1;
                4'd2:    ps_tgt = T_MSK2;
                4'd3:    ps_tgt = T_ARR_AR;
                4'd4:    ps_tgt = T_ARR_HP;
                default: ps_ok  = 1'b0;
            endcase
        end
        if (grp == GRP_PDST) begin
            pd_ok = 1'b1;
            case (sub)
                4'd0:    pd_tgt = T_CMP;
                4'd1:    pd_tgt = T_MSK1;
                4'd2:    pd_tgt = T_MSK2;
                4'd3:    pd_tgt = T_ARR_AR;
                4'd4:    pd_tgt = T_ARR_NF;
                4'd5:    pd_tgt = T_ARR_HP;
                default: pd_ok  = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/cam_rd_mux.sv
module cam_rd_mux
    import cam_rt_pkg::*;
#(
    parameter int              DATA_W = 16,
    parameter logic [OP_W-1:0] DEV_ID = 8'hA5
) (
    input  logic              oe,
    input  tgt_e              tgt,
    input  logic [2*DATA_W-1:0] stat,
    input  logic [DATA_W-1:0] rdata,
    input  logic [OP_W-1:0]   ps_op,
    input  logic [OP_W-1:0]   pd_op,
    output logic [DATA_W-1:0] dout
);
    localparam int PAD_W = DATA_W - 2*OP_W;

    always_comb begin
        dout = '0;
        if (oe) begin
            case (tgt)
                T_STLO:  dout = stat[DATA_W-1:0];
                T_STHI:  dout = stat[2*DATA_W-1:DATA_W];
                T_PS_RB: dout = {{PAD_W{1'b0}}, DEV_ID, ps_op};
                T_PD_RB: dout = {{PAD_W{1'b0}}, {OP_W{1'b0}}, pd_op};
                default: dout = rdata;
            endcase
        end
    end
endmodule

// File: rtl/cam_cycle_router.sv
module cam_cycle_router
    import cam_rt_pkg::*;
#(
    parameter int              DATA_W = 16,
    parameter int              AF_BIT = 11,
    parameter logic [OP_W-1:0] DEV_ID = 8'hA5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_en_n,
    input  logic                bus_dsel_i,
    input  logic                bus_rd_i,
    input  logic [DATA_W-1:0]   bus_din_i,
    input  logic [2*DATA_W-1:0] stat_i,
    input  logic [DATA_W-1:0]   reg_rdata_i,
    output logic [3:0]          tgt_o,
    output logic                wr_stb_o,
    output logic                rd_stb_o,
    output logic                dout_oe_o,
    output logic [DATA_W-1:0]   dout_o
);
    rt_state_t st_q, st_d;
    logic active;
    cyc_e kind;
    logic is_ovr, af, ps_ok, pd_ok;
    tgt_e ovr_tgt, ps_tgt, pd_tgt, tgt;

    cam_cyc_decode u_cyc (
        .en_n(bus_en_n), .dsel(bus_dsel_i), .rd(bus_rd_i),
        .active(active), .kind(kind)
    );

    cam_instr_decode u_ins (
        .op(bus_din_i[OP_W-1:0]), .af_bit(bus_din_i[AF_BIT]),
        .is_ovr(is_ovr), .ovr_tgt(ovr_tgt), .af(af),
        .ps_ok(ps_ok), .ps_tgt(ps_tgt), .pd_ok(pd_ok), .pd_tgt(pd_tgt)
    );

    always_comb begin
        st_d = st_q;
        tgt  = T_NONE;
        if (active) begin
            st_d.afl     = 1'b0;
            st_d.lo_seen = 1'b0;
            case (kind)
                CY_CMD_WR: begin
                    if (st_q.ovr_pend) begin
                        st_d.ovr_pend = 1'b0;
                        if (st_q.ovr_tgt inside {T_NFA, T_PS_RB, T_PD_RB})
                            tgt = T_NONE;
                        else
                            tgt = st_q.ovr_tgt;
                    end else if (st_q.afl) begin
                        tgt = T_ADDR;
                    end else begin
                        tgt = T_INSTR;
                        st_d.afl = af;
                        if (is_ovr) begin
                            st_d.ovr_pend = 1'b1;
                            st_d.ovr_tgt  = ovr_tgt;
                        end
                        if (ps_ok) begin
                            st_d.ps    = ps_tgt;
                            st_d.ps_op = bus_din_i[OP_W-1:0];
                        end
                        if (pd_ok) begin
                            st_d.pd    = pd_tgt;
                            st_d.pd_op = bus_din_i[OP_W-1:0];
                        end
                    end
                end
                CY_CMD_RD: begin
                    if (st_q.ovr_pend) begin
                        st_d.ovr_pend = 1'b0;
                        tgt = st_q.ovr_tgt;
                    end else if (st_q.lo_seen) begin
                        tgt = T_STHI;
                    end else begin
                        tgt = T_STLO;
                        st_d.lo_seen = 1'b1;
                    end
                end
                CY_DAT_WR: tgt = st_q.pd;
                default:   tgt = st_q.ps;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ovr_pend <= 1'b0;
            st_q.ovr_tgt  <= T_NONE;
            st_q.afl      <= 1'b0;
            st_q.lo_seen  <= 1'b0;
            st_q.ps       <= T_CMP;
            st_q.pd       <= T_CMP;
            st_q.ps_op    <= OP_PS_CMP;
            st_q.pd_op    <= OP_PD_CMP;
        end else begin
            st_q <= st_d;
        end
    end

    assign tgt_o     = tgt;
    assign rd_stb_o  = active & bus_rd_i;
    assign dout_oe_o = active & bus_rd_i;
    assign wr_stb_o  = active & ~bus_rd_i & (tgt != T_NONE);

    cam_rd_mux #(.DATA_W(DATA_W), .DEV_ID(DEV_ID)) u_mux (
        .oe(dout_oe_o), .tgt(tgt), .stat(stat_i), .rdata(reg_rdata_i),
        .ps_op(st_q.ps_op), .pd_op(st_q.pd_op), .dout(dout_o)
    );
endmodule

// File: rtl/cam_router_chk.sv
module cam_router_chk
    import cam_rt_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int AF_BIT = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_en_n,
    input logic              bus_dsel_i,
    input logic              bus_rd_i,
    input logic [DATA_W-1:0] bus_din_i,
    input logic [3:0]        tgt_o,
    input logic              wr_stb_o,
    input logic              rd_stb_o,
    input logic              dout_oe_o,
    input rt_state_t         st
);
    logic cmd_wr, cmd_rd, dat_rd;
    assign cmd_wr = !bus_en_n && !bus_dsel_i && !bus_rd_i;
    assign cmd_rd = !bus_en_n && !bus_dsel_i && bus_rd_i;
    assign dat_rd = !bus_en_n && bus_dsel_i && bus_rd_i;

    p_deselect_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        bus_en_n |-> (!dout_oe_o && !wr_stb_o && !rd_stb_o && tgt_o == 4'd0));

    p_deselect_hold_r1: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && bus_en_n) |-> $stable(st));

    p_default_instr_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !st.ovr_pend && !st.afl) |-> (tgt_o == 4'd1 && wr_stb_o));

    p_addr_flag_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && cmd_wr && tgt_o == 4'd1 && bus_din_i[AF_BIT]
               && bus_din_i[7:4] != GRP_OVR) && cmd_wr) |-> tgt_o == 4'd2);

    p_stat_pair_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && cmd_rd && tgt_o == 4'd6) && cmd_rd) |-> tgt_o == 4'd7);

    p_pair_break_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && !bus_en_n && bus_dsel_i) && cmd_rd && !st.ovr_pend)
            |-> tgt_o == 4'd6);

    p_ovr_once_r6: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !bus_en_n && !bus_dsel_i && st.ovr_pend) |-> !st.ovr_pend);

    p_ro_guard_r7: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |-> (tgt_o != 4'd5 && tgt_o != 4'd14 && tgt_o != 4'd15));

    p_persist_hold_r8: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !(cmd_wr && tgt_o == 4'd1)) |-> ($stable(st.ps) && $stable(st.pd)));

    p_src_range_r9: assert property (@(posedge clk) disable iff (rst)
        dat_rd |-> (tgt_o inside {4'd8, 4'd9, 4'd10, 4'd11, 4'd13}));
endmodule

bind cam_cycle_router cam_router_chk #(.DATA_W(DATA_W), .AF_BIT(AF_BIT)) u_chk (
    .clk(clk), .rst(rst), .bus_en_n(bus_en_n), .bus_dsel_i(bus_dsel_i),
    .bus_rd_i(bus_rd_i), .bus_din_i(bus_din_i), .tgt_o(tgt_o),
    .wr_stb_o(wr_stb_o), .rd_stb_o(rd_stb_o), .dout_oe_o(dout_oe_o), .st(st_q)
);

// File: tb/tb_cam_cycle_router.sv
module tb_cam_cycle_router;
    localparam logic [7:0] DEVID = 8'hA5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_n = 1'b1, dsel = 1'b0, rd = 1'b0;
    logic [15:0] din = '0;
    logic [31:0] stat = '0;
    logic [15:0] rdata = '0;
    logic [3:0]  tgt;
    logic        wstb, rstb, oe;
    logic [15:0] dout;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    bit       m_ovr, m_afl, m_lo;
    int       m_ovt, m_ps, m_pd;
    bit [7:0] m_psop, m_pdop;

    always #5 clk = ~clk;

    cam_cycle_router dut (
        .clk(clk), .rst(rst), .bus_en_n(en_n), .bus_dsel_i(dsel), .bus_rd_i(rd),
        .bus_din_i(din), .stat_i(stat), .reg_rdata_i(rdata), .tgt_o(tgt),
        .wr_stb_o(wstb), .rd_stb_o(rstb), .dout_oe_o(oe), .dout_o(dout)
    );

    function automatic int ovr_map(bit [3:0] s);
        case (s)
            1: return 2;  2: return 3;  3: return 4;
            4: return 5;  5: return 14; 6: return 15;
            default: return -1;
        endcase
    endfunction

    function automatic int src_map(bit [3:0] s);
        case (s)
            0: return 8; 1: return 9; 2: return 10; 3: return 11; 4: return 13;
            default: return -1;
        endcase
    endfunction

    function automatic int dst_map(bit [3:0] s);
        case (s)
            0: return 8; 1: return 9; 2: return 10; 3: return 11; 4: return 12; 5: return 13;
            default: return -1;
        endcase
    endfunction

    task automatic model_reset();
        m_ovr = 0; m_afl = 0; m_lo = 0; m_ovt = 0;
        m_ps = 8; m_pd = 8; m_psop = 8'h20; m_pdop = 8'h30;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1; en_n = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        rst = 1'b0;
        model_reset();
    endtask

    task automatic step(bit e_n, bit ds, bit r, bit [15:0] w, string tag_in);
        int    et;
        bit [15:0] ed;
        bit    ewr, erd;
        string tag;
        @(posedge clk); #1;
        en_n = e_n; dsel = ds; rd = r; din = w;
        stat = $urandom; rdata = $urandom[15:0];
        et = 0; tag = "R1";
        if (!e_n) begin
            case ({ds, r})
                2'b00: begin
                    if (m_ovr) begin
                        et = m_ovt; tag = m_afl ? "R11" : "R6";
                        if (et == 5 || et == 14 || et == 15) begin et = 0; tag = "R7"; end
                    end else if (m_afl) begin
                        et = 2; tag = "R3";
                    end else begin
                        et = 1; tag = "R2";
                    end
                end
                2'b01: begin
                    if (m_ovr) begin
                        et = m_ovt;
                        tag = (et >= 14) ? "R10" : (m_lo ? "R11" : "R6");
                    end else if (m_lo) begin
                        et = 7; tag = "R4";
                    end else begin
                        et = 6; tag = "R5";
                    end
                end
                2'b10: begin et = m_pd; tag = "R9"; end
                default: begin et = m_ps; tag = "R8"; end
            endcase
        end
        if (tag_in != "") tag = tag_in;
        erd = !e_n && r;
        ewr = !e_n && !r && et != 0;
        case (et)
            6:  ed = stat[15:0];
            7:  ed = stat[31:16];
            14: ed = {DEVID, m_psop};
            15: ed = {8'h00, m_pdop};
            default: ed = rdata;
        endcase
        #3;
        n_chk++;
        if (tgt !== 4'(et) || wstb !== ewr || rstb !== erd || oe !== erd
            || (erd && dout !== ed)) begin
            n_bad++;
            $display("FAIL %s: tgt=%0d wr=%0b rd=%0b oe=%0b dout=%h expected tgt=%0d wr=%0b rd=%0b oe=%0b dout=%h",
                     tag, tgt, wstb, rstb, oe, dout, et, ewr, erd, erd, ed);
        end
        if (!e_n) begin
            bit prev_ovr = m_ovr;
            m_afl = 0; m_lo = 0;
            if (!ds && prev_ovr) m_ovr = 0;
            if (!ds && !r && !prev_ovr && et == 1) begin
                m_afl = w[11];
                if (w[7:4] == 4'h1 && ovr_map(w[3:0]) >= 0) begin
                    m_ovr = 1; m_ovt = ovr_map(w[3:0]);
                end
                if (w[7:4] == 4'h2 && src_map(w[3:0]) >= 0) begin
                    m_ps = src_map(w[3:0]); m_psop = w[7:0];
                end
                if (w[7:4] == 4'h3 && dst_map(w[3:0]) >= 0) begin
                    m_pd = dst_map(w[3:0]); m_pdop = w[7:0];
                end
            end
            if (et == 6) m_lo = 1;
        end
    endtask

    task automatic cw(bit [15:0] w, string t); step(0, 0, 0, w, t); endtask
    task automatic cr(string t);               step(0, 0, 1, 16'h0, t); endtask
    task automatic dw(string t);               step(0, 1, 0, 16'h0, t); endtask
    task automatic dr(string t);               step(0, 1, 1, 16'h0, t); endtask
    task automatic idle(string t);             step(1, 0, 0, 16'h0, t); endtask

    function automatic bit [15:0] rnd_word();
        bit [7:0] ops [18] = '{8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16, 8'h10,
                               8'h20, 8'h21, 8'h22, 8'h23, 8'h24, 8'h27,
                               8'h30, 8'h32, 8'h34, 8'h35, 8'h3F};
        bit [15:0] w = $urandom[15:0];
        if ($urandom_range(0, 3) != 0) w[7:0] = ops[$urandom_range(0, 17)];
        return w;
    endfunction

    initial begin
        void'($urandom(32'd7341));
        model_reset();
        do_reset();
        // R12 / R8: defaults after reset
        dr("R12"); dw("R8"); cr("R12"); cr("R4"); cr("R4");
        // R4 / R5 pairing
        cr("R4"); cr("R4"); cr("R5"); dw("R5"); cr("R5");
        // R1: deselect keeps the pairing
        cr("R1"); idle("R1"); cr("R1");
        // R3 flag then address write; flag dropped by a data cycle
        cw(16'h0800, "R3"); cw(16'h1234, "R3");
        cw(16'h0800, "R3"); dr("R3"); cw(16'h0000, "R3");
        // R6 override survives a data cycle, one shot
        cw(16'h0012, "R6"); dr("R6"); cr("R6"); cr("R6");
        // R7 write protection under NFA override
        cw(16'h0014, "R7"); cw(16'hFFFF, "R7"); cw(16'h0000, "R7");
        // R8 select and invalid select
        cw(16'h0022, "R8"); dr("R8"); cw(16'h0027, "R8"); dr("R8");
        cw(16'h0034, "R8"); dw("R9"); cw(16'h003F, "R8"); dw("R9");
        // R10 readback
        cw(16'h0015, "R10"); cr("R10"); cw(16'h0016, "R10"); cr("R10");
        // R11 override beats flag and pairing
        cw(16'h0811, "R11"); cw(16'h5555, "R11"); cw(16'h0000, "R11");
        cr("R11"); cw(16'h0013, "R11"); cr("R11"); cr("R11");
        // R12 mid-stream reset
        cw(16'h0823, "R12"); cr("R12");
        cw(16'h0812, "R12");
        do_reset();
        cw(16'h0000, "R12"); cr("R12"); dr("R12"); cw(16'h0016, "R12"); cr("R12");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            bit e_n = ($urandom_range(0, 7) == 0);
            step(e_n, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, rnd_word(), "");
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule